// File: doc/BRIEF.md
# Interrupt Vector Arbiter

The block gathers 64 level-sensitive interrupt lines and turns them into a single interrupt vector request toward the processor. Lines 0 to 31 come from expansion-bus slots. Each group of four slot lines shares one mapping register, so there are 8 of them. Lines 32 to 63 come from on-board devices, and each of these has its own mapping register, giving 32 more. Each mapping register holds an enable bit that software can write. Its remaining bits are fixed routing information that software can only read.

Only one request can be outstanding at any time. It appears as a single set bit on a 64-bit one-hot output. Software removes the request in one of two ways: by writing a clear register, or by disabling the mapping that produced it. After a successful clear, or after any write to a mapping register, the block scans the pending lines and promotes the lowest-numbered enabled one. Because of that ordering, slot lines always win over on-board lines.

Top module: `irq_vector_arbiter`

## Requirements
- R1: A synchronous active-low reset clears every enable bit, empties the pending set and drives `irq_req` to zero. A mapping register read after reset shows bit 31 as 0.
- R2: In a mapping register only bit 31 (enable) is writable. Bits 30:0 always read as fixed values: 0x7C0 | (g<<2) for slot mapping register g, and 0x7C0 | (32+k) for on-board mapping register k.
- R3: Slot line n (n < 32) is governed by slot mapping register n>>2. On-board line 32+k is governed by on-board mapping register k. A line whose register is disabled never produces a request.
- R4: An enabled slot line that rises, measured against its level at the previous clock edge, becomes the request on the next cycle. It replaces any outstanding request. When several slot lines rise together, the lowest one wins.
- R5: An enabled on-board line that rises becomes the request only when no request remains outstanding after that cycle's clears and rescans.
- R6: `irq_req` has at most one bit set. Bit i set means that line i is the outstanding request.
- R7: An outstanding request is held while its input drops and while other on-board lines rise. Only a clear, a disable or a newer slot request changes it.
- R8: A write to slot clear register g removes the request when its line number divided by 4 equals g. A write to any other slot clear register leaves the request unchanged.
- R9: A write to on-board clear register k removes the request only when the request is line 32+k.
- R10: After a successful clear, or after any mapping write, the request is chosen as follows. If a request is still outstanding, it is kept. Otherwise the lowest line that was pending at the previous clock edge and is enabled becomes the request, so slot lines come before on-board lines.
- R11: A mapping write with bit 31 = 0 cancels the outstanding request if that request's line is governed by the written register. The rescan of R10 follows.
- R12: The register address is split into fields. Bits 11:8 select the region: 0 for slot mapping, 1 for on-board mapping, 2 for slot clear, 3 for on-board clear. Bits 7:3 hold the index, and bit 2 must be 1 for the data word. Accesses with bit 2 = 0 read zero and writes to them are ignored. Clear registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Level interrupt lines, slot lines 0-31 and on-board lines 32-63 |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 12 | Register address, used for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | output | 64 | One-hot outstanding interrupt vector request |

## Verification
Two functions can land in the same cycle: a register write that clears or disables the current request, and a rising input on another line. The bench provokes this by issuing a clear write in the same cycle that a slot line rises. The slot line must end up as the request even though the rescan had already chosen a different pending line. It also pairs a clear with a rising on-board line while nothing remains pending; there the on-board line must be accepted because the clear left no request outstanding. In every one of these cases the outcome is judged from `irq_req` one cycle after the write.

// File: rtl/intarb_pkg.sv
// Shared constants and types for the interrupt vector arbiter.
// Assumes a 12-bit register address with the field layout given in the brief.
package intarb_pkg;

    localparam int ADDR_W      = 12;
    localparam int IDX_FIELD_W = 5;

    localparam logic [3:0] RGN_PCI_MAP = 4'h0;
    localparam logic [3:0] RGN_OB_MAP  = 4'h1;
    localparam logic [3:0] RGN_PCI_CLR = 4'h2;
    localparam logic [3:0] RGN_OB_CLR  = 4'h3;

    localparam logic [30:0] LOW_BASE = 31'h7C0;

    // One decoded register write, valid for a single cycle
    typedef struct packed {
        logic                   map_pci;
        logic                   map_ob;
        logic                   clr_pci;
        logic                   clr_ob;
        logic                   en;
        logic [IDX_FIELD_W-1:0] idx;
    } wr_cmd_t;

    // Fixed low bits of slot mapping register g
    function automatic logic [30:0] pci_low_bits(input int g);
        return LOW_BASE | 31'(g << 2);
    endfunction

    // Fixed low bits of on-board mapping register k
    function automatic logic [30:0] ob_low_bits(input int k, input int base);
        return LOW_BASE | 31'(base + k);
    endfunction

endpackage

// File: rtl/intarb_pick.sv
// Lowest-index priority encoder.
// Assumes IW bits are enough to hold W-1.
module intarb_pick #(
    parameter int W  = 64,
    parameter int IW = 6
) (
    input  logic [W-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Walk from the top down so that the lowest set bit is the last one assigned
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/intarb_regs.sv
// Register file of the arbiter: address decode, enable storage and readback.
// Only the enable bits are stored; the fixed low bits are computed.
// Assumes OB_LINES <= 32 and PCI_GROUPS <= 32 (5-bit index field).
module intarb_regs
    import intarb_pkg::*;
#(
    parameter int PCI_GROUPS = 8,
    parameter int OB_LINES   = 32,
    parameter int PCI_LINES  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output wr_cmd_t               cmd,
    output logic [PCI_GROUPS-1:0] en_pci_d,
    output logic [OB_LINES-1:0]   en_ob_d
);

    logic [PCI_GROUPS-1:0]  en_pci_q;
    logic [OB_LINES-1:0]    en_ob_q;
    logic [3:0]             rgn;
    logic [IDX_FIELD_W-1:0] idx;
    logic                   hiword;
    logic                   unused_bits;

    assign rgn         = addr[11:8];
    assign idx         = addr[7:3];
    assign hiword      = addr[2];
    assign unused_bits = ^{addr[1:0], wdata[30:0]};

    // Decode a write into one command; out-of-range indices are dropped
    always_comb begin
        cmd     = '0;
        cmd.idx = idx;
        cmd.en  = wdata[31];
        if (wr && hiword) begin
            case (rgn)
                RGN_PCI_MAP: cmd.map_pci = (int'(idx) < PCI_GROUPS);
                RGN_OB_MAP:  cmd.map_ob  = (int'(idx) < OB_LINES);
                RGN_PCI_CLR: cmd.clr_pci = (int'(idx) < PCI_GROUPS);
                RGN_OB_CLR:  cmd.clr_ob  = (int'(idx) < OB_LINES);
                default:     cmd.idx     = idx;
            endcase
        end
    end

    // Next enable values, per register
    for (genvar g = 0; g < PCI_GROUPS; g++) begin : g_pci_en
        assign en_pci_d[g] = (cmd.map_pci && int'(cmd.idx) == g) ? cmd.en : en_pci_q[g];
    end
    for (genvar k = 0; k < OB_LINES; k++) begin : g_ob_en
        assign en_ob_d[k] = (cmd.map_ob && int'(cmd.idx) == k) ? cmd.en : en_ob_q[k];
    end

    // Enable storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_pci_q <= '0;
            en_ob_q  <= '0;
        end else begin
            en_pci_q <= en_pci_d;
            en_ob_q  <= en_ob_d;
        end
    end

    // Readback mux: mapping registers only, upper word only
    always_comb begin
        rdata = '0;
        if (hiword) begin
            if (rgn == RGN_PCI_MAP) begin
                for (int g = 0; g < PCI_GROUPS; g++) begin
                    if (int'(idx) == g) rdata = {en_pci_q[g], pci_low_bits(g)};
                end
            end else if (rgn == RGN_OB_MAP) begin
                for (int k = 0; k < OB_LINES; k++) begin
                    if (int'(idx) == k) rdata = {en_ob_q[k], ob_low_bits(k, PCI_LINES)};
                end
            end
        end
    end

endmodule

// File: rtl/intarb_core.sv
// Request engine: pending set, rise detection, clear/cancel and rescan.
// Holds one request at a time. Assumes the decoded command and the next
// enable values come from the register block in the same cycle.
module intarb_core
    import intarb_pkg::*;
#(
    parameter int PCI_GROUPS  = 8,
    parameter int GROUP_LINES = 4,
    parameter int OB_LINES    = 32,
    parameter int PCI_LINES   = 32,
    parameter int NUM_LINES   = 64,
    parameter int IDX_W       = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  wr_cmd_t               cmd,
    input  logic [PCI_GROUPS-1:0] en_pci_d,
    input  logic [OB_LINES-1:0]   en_ob_d,
    input  logic [NUM_LINES-1:0]  irq_in,
    output logic [NUM_LINES-1:0]  irq_req,
    output logic [NUM_LINES-1:0]  pend
);

    localparam logic [NUM_LINES-1:0] PCI_MASK = {{OB_LINES{1'b0}}, {PCI_LINES{1'b1}}};

    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] line_en;
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] scan_vec;
    logic [NUM_LINES-1:0] rise_pci_vec;
    logic [NUM_LINES-1:0] rise_ob_vec;
    logic                 req_v_q, req_v_d;
    logic [IDX_W-1:0]     req_idx_q, req_idx_d;
    logic                 scan_hit, rp_hit, ro_hit;
    logic [IDX_W-1:0]     scan_idx, rp_idx, ro_idx;
    logic                 drop;
    logic                 rescan;
    int                   req_int;

    // Per-line enable taken from the governing mapping register
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line_en
        if (n < PCI_LINES) begin : g_pci
            assign line_en[n] = en_pci_d[n / GROUP_LINES];
        end else begin : g_ob
            assign line_en[n] = en_ob_d[n - PCI_LINES];
        end
    end

    assign rise         = irq_in & ~pend_q;
    assign scan_vec     = pend_q & line_en;
    assign rise_pci_vec = rise & line_en & PCI_MASK;
    assign rise_ob_vec  = rise & line_en & ~PCI_MASK;
    assign req_int      = int'(req_idx_q);

    intarb_pick #(.W(NUM_LINES), .IW(IDX_W)) u_pick_scan (
        .vec(scan_vec), .hit(scan_hit), .idx(scan_idx));
    intarb_pick #(.W(NUM_LINES), .IW(IDX_W)) u_pick_rpci (
        .vec(rise_pci_vec), .hit(rp_hit), .idx(rp_idx));
    intarb_pick #(.W(NUM_LINES), .IW(IDX_W)) u_pick_rob (
        .vec(rise_ob_vec), .hit(ro_hit), .idx(ro_idx));

    // Does this cycle's write remove the outstanding request
    always_comb begin
        drop = 1'b0;
        if (req_v_q) begin
            if (req_int < PCI_LINES) begin
                if (((cmd.map_pci && !cmd.en) || cmd.clr_pci) &&
                    (req_int / GROUP_LINES) == int'(cmd.idx)) drop = 1'b1;
            end else begin
                if (((cmd.map_ob && !cmd.en) || cmd.clr_ob) &&
                    (req_int - PCI_LINES) == int'(cmd.idx)) drop = 1'b1;
            end
        end
    end

    assign rescan = cmd.map_pci | cmd.map_ob | drop;

    // Next request: rescan, then slot rise overrides, then on-board rise if idle
    always_comb begin
        req_v_d   = req_v_q && !drop;
        req_idx_d = req_idx_q;
        if (rescan && !req_v_d && scan_hit) begin
            req_v_d   = 1'b1;
            req_idx_d = scan_idx;
        end
        if (rp_hit) begin
            req_v_d   = 1'b1;
            req_idx_d = rp_idx;
        end else if (!req_v_d && ro_hit) begin
            req_v_d   = 1'b1;
            req_idx_d = ro_idx;
        end
    end

    // Pending set and request state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            req_v_q   <= 1'b0;
            req_idx_q <= '0;
        end else begin
            pend_q    <= irq_in;
            req_v_q   <= req_v_d;
            req_idx_q <= req_idx_d;
        end
    end

    // One-hot request output
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_req
        assign irq_req[n] = req_v_q && (req_int == n);
    end

    assign pend = pend_q;

endmodule

// File: rtl/irq_vector_arbiter.sv
// Top of the interrupt vector arbiter: register block plus request engine.
// Assumes a single-cycle write strobe and a combinational read path.
module irq_vector_arbiter
    import intarb_pkg::*;
#(
    parameter  int PCI_GROUPS  = 8,
    parameter  int GROUP_LINES = 4,
    parameter  int OB_LINES    = 32,
    localparam int PCI_LINES   = PCI_GROUPS * GROUP_LINES,
    localparam int NUM_LINES   = PCI_LINES + OB_LINES,
    localparam int IDX_W       = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_LINES-1:0] irq_req
);

    wr_cmd_t               cmd;
    logic [PCI_GROUPS-1:0] en_pci_d;
    logic [OB_LINES-1:0]   en_ob_d;
    logic [NUM_LINES-1:0]  pend_q;

    intarb_regs #(
        .PCI_GROUPS(PCI_GROUPS), .OB_LINES(OB_LINES), .PCI_LINES(PCI_LINES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .cmd(cmd), .en_pci_d(en_pci_d), .en_ob_d(en_ob_d)
    );

    intarb_core #(
        .PCI_GROUPS(PCI_GROUPS), .GROUP_LINES(GROUP_LINES), .OB_LINES(OB_LINES),
        .PCI_LINES(PCI_LINES), .NUM_LINES(NUM_LINES), .IDX_W(IDX_W)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .en_pci_d(en_pci_d), .en_ob_d(en_ob_d),
        .irq_in(irq_in), .irq_req(irq_req), .pend(pend_q)
    );

endmodule

// File: rtl/irq_vector_arbiter_chk.sv
// Property checker for the interrupt vector arbiter, bound to the top.
module irq_vector_arbiter_chk #(
    parameter int NUM_LINES = 64,
    parameter int PCI_LINES = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic                 word_sel,
    input logic [31:0]          reg_rdata,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] irq_req,
    input logic [NUM_LINES-1:0] pend
);

    // R6: never more than one request
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_req));

    // R1: first cycle out of reset has no request
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_req == '0));

    // R7: without a write or a rising slot line the request does not move
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|irq_req) && !reg_wr &&
         ((irq_in[PCI_LINES-1:0] & ~pend[PCI_LINES-1:0]) == '0)) |=> $stable(irq_req));

    // R12: lower-word reads return zero
    p_loword_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !word_sel |-> (reg_rdata == 32'h0));

endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk #(
    .NUM_LINES(NUM_LINES), .PCI_LINES(PCI_LINES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .word_sel(reg_addr[2]),
    .reg_rdata(reg_rdata), .irq_in(irq_in), .irq_req(irq_req), .pend(pend_q)
);

// File: tb/irq_vector_arbiter_test.sv
module irq_vector_arbiter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] irq_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_vector_arbiter uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req)
    );

    // Row: {write, addr, data, irq_in, expected irq_req one cycle later}
    localparam int NSTEPS = 22;
    localparam logic [172:0] STEPS [NSTEPS] = '{
        {1'b1, 12'h00C, 32'h8000_0000, 64'h0,                64'h0},
        {1'b0, 12'h000, 32'h0,         64'h20,               64'h20},
        {1'b0, 12'h000, 32'h0,         64'h30,               64'h10},
        {1'b0, 12'h000, 32'h0,         64'h20,               64'h10},
        {1'b1, 12'h114, 32'h8000_0000, 64'h20,               64'h10},
        {1'b0, 12'h000, 32'h0,         64'h4_0000_0020,      64'h10},
        {1'b1, 12'h20C, 32'h0,         64'h4_0000_0020,      64'h20},
        {1'b1, 12'h204, 32'h0,         64'h4_0000_0020,      64'h20},
        {1'b1, 12'h314, 32'h0,         64'h4_0000_0020,      64'h20},
        {1'b0, 12'h000, 32'h0,         64'h4_0000_0000,      64'h20},
        {1'b1, 12'h20C, 32'h0,         64'h4_0000_0000,      64'h4_0000_0000},
        {1'b1, 12'h31C, 32'h0,         64'h4_0000_0000,      64'h4_0000_0000},
        {1'b1, 12'h310, 32'h0,         64'h4_0000_0000,      64'h4_0000_0000},
        {1'b1, 12'h110, 32'h0,         64'h4_0000_0000,      64'h4_0000_0000},
        {1'b1, 12'h114, 32'h0,         64'h4_0000_0000,      64'h0},
        {1'b0, 12'h000, 32'h0,         64'h0,                64'h0},
        {1'b0, 12'h000, 32'h0,         64'h100_0000_0000,    64'h0},
        {1'b1, 12'h144, 32'h8000_0000, 64'h100_0000_0000,    64'h100_0000_0000},
        {1'b0, 12'h000, 32'h0,         64'h100_0000_1000,    64'h100_0000_0000},
        {1'b1, 12'h01C, 32'h8000_0000, 64'h100_0000_1000,    64'h100_0000_0000},
        {1'b1, 12'h344, 32'h0,         64'h100_0000_1000,    64'h1000},
        {1'b1, 12'h01C, 32'h7FFF_FFFF, 64'h100_0000_1000,    64'h100_0000_0000}
    };
    string tags [NSTEPS] = '{
        "R3", "R4", "R4", "R7", "R10", "R5", "R8", "R8", "R9", "R7", "R10",
        "R9", "R12", "R12", "R11", "R11", "R3", "R3", "R3", "R10", "R10", "R11"
    };

    function automatic logic [31:0] exp_map(input bit ob, input int i, input bit en);
        int low;
        low = ob ? (32'h7C0 | (32 + i)) : (32'h7C0 | (i * 4));
        return {en, low[30:0]};
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: irq_req=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: reg_rdata=%h expected %h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, result sampled just after the capturing edge
    task automatic do_step(input logic w, input logic [11:0] a, input logic [31:0] d,
                           input logic [63:0] v, input logic [63:0] e, input string tag);
        @(negedge clk);
        reg_wr = w; reg_addr = a; reg_wdata = d; irq_in = v;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        check64(tag, irq_req, e);
        checks++;
        if ($countones(irq_req) > 1) begin
            errors++;
            $display("FAIL R6: irq_req=%h expected at most one bit", irq_req);
        end
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1;
        check32(tag, reg_rdata, e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 / R2: reset state and fixed low bits
        check64("R1", irq_req, 64'h0);
        do_read(12'h004, exp_map(0, 0, 0), "R1");
        do_read(12'h03C, exp_map(0, 7, 0), "R2");
        do_read(12'h104, exp_map(1, 0, 0), "R2");
        do_read(12'h1FC, exp_map(1, 31, 0), "R2");
        do_read(12'h038, 32'h0, "R12");

        for (int i = 0; i < NSTEPS; i++) begin
            do_step(STEPS[i][172], STEPS[i][171:160], STEPS[i][159:128],
                    STEPS[i][127:64], STEPS[i][63:0], tags[i]);
        end

        // R2: only bit 31 took effect
        do_read(12'h00C, exp_map(0, 1, 1), "R2");
        do_read(12'h01C, exp_map(0, 3, 0), "R2");
        do_read(12'h114, exp_map(1, 2, 0), "R2");
        do_read(12'h144, exp_map(1, 8, 1), "R2");
        do_read(12'h140, 32'h0, "R12");
        do_read(12'h20C, 32'h0, "R12");

        // R1: reset while a request is outstanding
        do_reset();
        check64("R1", irq_req, 64'h0);
        do_read(12'h00C, exp_map(0, 1, 0), "R1");

        // Coincident write and rise cases
        do_step(1'b1, 12'h104, 32'h8000_0000, 64'h0, 64'h0, "R3");
        do_step(1'b1, 12'h004, 32'h8000_0000, 64'h0, 64'h0, "R3");
        do_step(1'b1, 12'h10C, 32'h8000_0000, 64'h0, 64'h0, "R3");
        do_step(1'b0, 12'h000, 32'h0, 64'h1_0000_0000, 64'h1_0000_0000, "R5");
        do_step(1'b1, 12'h304, 32'h0, 64'h1_0000_0002, 64'h2, "R4");
        do_step(1'b0, 12'h000, 32'h0, 64'h1_0000_0000, 64'h2, "R7");
        do_step(1'b1, 12'h204, 32'h0, 64'h1_0000_0000, 64'h1_0000_0000, "R8");
        do_step(1'b0, 12'h000, 32'h0, 64'h0, 64'h1_0000_0000, "R7");
        do_step(1'b1, 12'h304, 32'h0, 64'h2_0000_0000, 64'h2_0000_0000, "R9");
        do_step(1'b0, 12'h000, 32'h0, 64'h2_0000_0004, 64'h4, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule